// File: doc/BRIEF.md
# Prioritized Interrupt Level Evaluator

This block gathers software-posted and externally signalled interrupt requests and works out the highest pending priority level. When an evaluate strobe arrives, it compares that level with a locally held current priority level. If the pending level is higher, the block emits a one-cycle take pulse. On the same edge it latches a summary of every pending request bit and the winning level. The surrounding trap logic acts on the pulse. This block neither enters the trap nor handles asynchronous trap requests.

Software requests sit in a masked register and map to levels offset from their bit positions. External requests map to levels equal to their bit positions and always outrank software requests. Both sources feed one shared summary vector. A pending asynchronous trap request is flagged as an unsupported condition and takes no part in the level computation.

Top module: `irq_level_eval`

## Requirements
- R1: The software request register stores only bits 4 to 18 of a write. All other bits read back as 0 on `sw_req_o` from the cycle after the write.
- R2: The current level register stores only the low 5 bits of a write. They read back on `ipl_o` from the cycle after the write.
- R3: For software requests alone, the level is (i - 4) + 1, where i is the highest set software bit. Bit 4 gives level 1 and bit 18 gives level 15.
- R4: A set external request bit i in the range 20 to 23 gives level i. The highest such bit wins, and it overrides any software level.
- R5: External request bits outside 20 to 23 have no effect on the level, the take decision or the summary.
- R6: An interrupt is taken only when the level is nonzero and strictly greater than the current level register. The take pulse is high for exactly the one cycle after the strobe edge.
- R7: On a take, `summary_o` holds the OR of all in-range pending software and external bits at their own positions, and `intid_o` holds the level. Both appear in the same cycle as the pulse.
- R8: When an evaluation does not take an interrupt, or when no evaluation occurs, `summary_o` and `intid_o` keep their previous values.
- R9: An asynchronous trap request present at an evaluation raises `ast_err_o` for the following cycle. It does not change the level or the take decision.
- R10: After reset, every register output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sw_we_i | input | 1 | Software request register write enable |
| sw_wdata_i | input | SUM_W | Software request write data |
| ipl_we_i | input | 1 | Current level register write enable |
| ipl_wdata_i | input | IPL_IN_W | Current level write data |
| ext_req_i | input | SUM_W | External request lines |
| ast_req_i | input | 1 | Asynchronous trap request (unsupported) |
| eval_i | input | 1 | Evaluate strobe |
| sw_req_o | output | SUM_W | Software request register contents |
| ipl_o | output | LVL_W | Current level register contents |
| take_o | output | 1 | Interrupt take pulse |
| summary_o | output | SUM_W | Latched pending request summary |
| intid_o | output | LVL_W | Latched interrupt level |
| ast_err_o | output | 1 | Unsupported asynchronous trap flag |

## Verification
The assertions check the following on every cycle:
- a take pulse always follows a strobe, carries a nonzero level and beats the previous current level;
- the summary and level outputs stay fixed whenever no take occurs;
- the software register never holds bits outside its window;
- the error flag always follows a strobe with an asynchronous request.

Other behaviour can only be shown by the bench scenarios:
- the exact level mapping, including the software offset and external override;
- the strict comparison at equal levels;
- that out-of-range external lines are ignored;
- the summary contents.

// File: rtl/irq_eval_pkg.sv
package irq_eval_pkg;
  localparam int unsigned MAX_SPAN = 64;

  function automatic logic [MAX_SPAN-1:0] span_mask(int lo, int hi);
    logic [MAX_SPAN-1:0] m;
    m = '0;
    for (int i = 0; i < MAX_SPAN; i++)
      if (i >= lo && i < hi) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
  import irq_eval_pkg::*;
#(
  parameter int unsigned SUM_W    = 32,
  parameter int unsigned SW_MIN   = 4,
  parameter int unsigned SW_MAX   = 19,
  parameter int unsigned LVL_W    = 5,
  parameter int unsigned IPL_IN_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sw_we_i,
  input  logic [SUM_W-1:0]    sw_wdata_i,
  input  logic                ipl_we_i,
  input  logic [IPL_IN_W-1:0] ipl_wdata_i,
  output logic [SUM_W-1:0]    sw_q_o,
  output logic [LVL_W-1:0]    ipl_q_o
);
  localparam logic [SUM_W-1:0] SW_MASK = SUM_W'(span_mask(SW_MIN, SW_MAX));

  logic unused_ipl_hi;
  assign unused_ipl_hi = ^ipl_wdata_i[IPL_IN_W-1:LVL_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q_o  <= '0;
      ipl_q_o <= '0;
    end else begin
      if (sw_we_i)  sw_q_o  <= sw_wdata_i & SW_MASK;
      if (ipl_we_i) ipl_q_o <= ipl_wdata_i[LVL_W-1:0];
    end
  end

  assert_sw_window_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_q_o & ~SW_MASK) == '0);

  assert_ipl_follows_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ipl_we_i |=> ipl_q_o == $past(ipl_wdata_i[LVL_W-1:0]));
endmodule

// File: rtl/irq_sw_scan.sv
module irq_sw_scan
  import irq_eval_pkg::*;
#(
  parameter int unsigned SUM_W  = 32,
  parameter int unsigned SW_MIN = 4,
  parameter int unsigned SW_MAX = 19,
  parameter int unsigned LVL_W  = 5
) (
  input  logic [SUM_W-1:0] req_i,
  output logic [SUM_W-1:0] bits_o,
  output logic [LVL_W-1:0] lvl_o
);
  localparam logic [SUM_W-1:0] WIN = SUM_W'(span_mask(SW_MIN, SW_MAX));

  logic unused_out_of_win;
  assign unused_out_of_win = ^(req_i & ~WIN);
  assign bits_o = req_i & WIN;

  // ascending scan: highest set bit wins, levels offset to start at 1
  always_comb begin
    lvl_o = '0;
    for (int i = SW_MIN; i < SW_MAX; i++)
      if (req_i[i]) lvl_o = LVL_W'(i - SW_MIN + 1);
  end
endmodule

// File: rtl/irq_ext_scan.sv
module irq_ext_scan
  import irq_eval_pkg::*;
#(
  parameter int unsigned SUM_W   = 32,
  parameter int unsigned EXT_MIN = 20,
  parameter int unsigned EXT_MAX = 24,
  parameter int unsigned LVL_W   = 5
) (
  input  logic [SUM_W-1:0] req_i,
  output logic [SUM_W-1:0] bits_o,
  output logic [LVL_W-1:0] lvl_o,
  output logic             hit_o
);
  localparam logic [SUM_W-1:0] WIN = SUM_W'(span_mask(EXT_MIN, EXT_MAX));

  logic unused_out_of_win;
  assign unused_out_of_win = ^(req_i & ~WIN);
  assign bits_o = req_i & WIN;
  assign hit_o  = |bits_o;

  always_comb begin
    lvl_o = '0;
    for (int i = EXT_MIN; i < EXT_MAX; i++)
      if (req_i[i]) lvl_o = LVL_W'(i);
  end
endmodule

// File: rtl/irq_level_eval.sv
module irq_level_eval #(
  parameter int unsigned SUM_W    = 32,
  parameter int unsigned SW_MIN   = 4,
  parameter int unsigned SW_MAX   = 19,
  parameter int unsigned EXT_MIN  = 20,
  parameter int unsigned EXT_MAX  = 24,
  parameter int unsigned LVL_W    = 5,
  parameter int unsigned IPL_IN_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sw_we_i,
  input  logic [SUM_W-1:0]    sw_wdata_i,
  input  logic                ipl_we_i,
  input  logic [IPL_IN_W-1:0] ipl_wdata_i,
  input  logic [SUM_W-1:0]    ext_req_i,
  input  logic                ast_req_i,
  input  logic                eval_i,
  output logic [SUM_W-1:0]    sw_req_o,
  output logic [LVL_W-1:0]    ipl_o,
  output logic                take_o,
  output logic [SUM_W-1:0]    summary_o,
  output logic [LVL_W-1:0]    intid_o,
  output logic                ast_err_o
);
  logic [SUM_W-1:0] sw_q, sw_bits, ext_bits, sum_d;
  logic [LVL_W-1:0] ipl_q, sw_lvl, ext_lvl, lvl_d;
  logic             ext_hit, take_d;

  irq_ctl_regs #(
    .SUM_W(SUM_W), .SW_MIN(SW_MIN), .SW_MAX(SW_MAX),
    .LVL_W(LVL_W), .IPL_IN_W(IPL_IN_W)
  ) u_regs (
    .clk_i, .rst_ni,
    .sw_we_i, .sw_wdata_i,
    .ipl_we_i, .ipl_wdata_i,
    .sw_q_o (sw_q),
    .ipl_q_o(ipl_q)
  );

  irq_sw_scan #(
    .SUM_W(SUM_W), .SW_MIN(SW_MIN), .SW_MAX(SW_MAX), .LVL_W(LVL_W)
  ) u_sw_scan (
    .req_i (sw_q),
    .bits_o(sw_bits),
    .lvl_o (sw_lvl)
  );

  irq_ext_scan #(
    .SUM_W(SUM_W), .EXT_MIN(EXT_MIN), .EXT_MAX(EXT_MAX), .LVL_W(LVL_W)
  ) u_ext_scan (
    .req_i (ext_req_i),
    .bits_o(ext_bits),
    .lvl_o (ext_lvl),
    .hit_o (ext_hit)
  );

  // external requests outrank all software ones; async trap is not folded in
  assign lvl_d  = ext_hit ? ext_lvl : sw_lvl;
  assign sum_d  = sw_bits | ext_bits;
  assign take_d = eval_i && (lvl_d != '0) && (lvl_d > ipl_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_o    <= 1'b0;
      summary_o <= '0;
      intid_o   <= '0;
      ast_err_o <= 1'b0;
    end else begin
      take_o    <= take_d;
      ast_err_o <= eval_i && ast_req_i;
      if (take_d) begin
        summary_o <= sum_d;
        intid_o   <= lvl_d;
      end
    end
  end

  assign sw_req_o = sw_q;
  assign ipl_o    = ipl_q;

  assert_take_after_eval_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $past(eval_i));

  assert_take_beats_ipl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (intid_o != '0) && (intid_o > $past(ipl_q)));

  assert_hold_without_take_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> $stable(summary_o) && $stable(intid_o));

  assert_ast_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ast_err_o |-> $past(eval_i && ast_req_i));

  assert_ext_overrides_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && ext_hit && (ext_lvl > ipl_q)) |=> take_o && intid_o >= LVL_W'(EXT_MIN));
endmodule

// File: tb/irq_level_eval_bench.sv
module irq_level_eval_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_we = 1'b0, ipl_we = 1'b0, ast_req = 1'b0, eval = 1'b0;
  logic [31:0] sw_wdata = '0, ext_req = '0;
  logic [7:0]  ipl_wdata = '0;
  logic [31:0] sw_req, summary;
  logic [4:0]  ipl, intid;
  logic        take, ast_err;

  int checks = 0, errors = 0;
  logic [31:0] m_sw = '0, m_sum = '0;
  logic [4:0]  m_ipl = '0, m_id = '0;

  always #10 clk = ~clk;

  irq_level_eval u_irq_level_eval (
    .clk_i(clk), .rst_ni(rst_n),
    .sw_we_i(sw_we), .sw_wdata_i(sw_wdata),
    .ipl_we_i(ipl_we), .ipl_wdata_i(ipl_wdata),
    .ext_req_i(ext_req), .ast_req_i(ast_req), .eval_i(eval),
    .sw_req_o(sw_req), .ipl_o(ipl), .take_o(take),
    .summary_o(summary), .intid_o(intid), .ast_err_o(ast_err)
  );

  function automatic logic [4:0] exp_level(logic [31:0] sw, logic [31:0] ext);
    logic [4:0] l = '0;
    for (int i = 4; i <= 18; i++) if (sw[i]) l = 5'(i - 3);
    for (int i = 20; i <= 23; i++) if (ext[i]) l = 5'(i);
    return l;
  endfunction

  function automatic logic [31:0] exp_sum(logic [31:0] sw, logic [31:0] ext);
    return (sw & 32'h0007_fff0) | (ext & 32'h00f0_0000);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic write_sw(logic [31:0] d);
    @(negedge clk); sw_we = 1'b1; sw_wdata = d;
    @(negedge clk); sw_we = 1'b0;
    m_sw = d & 32'h0007_fff0;
    chk("R1 sw_req", sw_req, m_sw);
  endtask

  task automatic write_ipl(logic [7:0] d);
    @(negedge clk); ipl_we = 1'b1; ipl_wdata = d;
    @(negedge clk); ipl_we = 1'b0;
    m_ipl = d[4:0];
    chk("R2 ipl", 32'(ipl), 32'(m_ipl));
  endtask

  task automatic do_eval(logic [31:0] ext, logic ast);
    logic [4:0] l;
    logic       t;
    l = exp_level(m_sw, ext);
    t = (l != 0) && (l > m_ipl);
    if (t) begin
      m_sum = exp_sum(m_sw, ext);
      m_id  = l;
    end
    @(negedge clk); ext_req = ext; ast_req = ast; eval = 1'b1;
    @(negedge clk); eval = 1'b0; ast_req = 1'b0;
    chk("R6 take", 32'(take), 32'(t));
    chk("R7/R8 summary", summary, m_sum);
    chk("R3/R4/R7 intid", 32'(intid), 32'(m_id));
    chk("R9 ast_err", 32'(ast_err), 32'(ast));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 sw_req", sw_req, 0);
    chk("R10 ipl", 32'(ipl), 0);
    chk("R10 take", 32'(take), 0);
    chk("R10 summary", summary, 0);
    chk("R10 intid", 32'(intid), 0);
    chk("R10 ast_err", 32'(ast_err), 0);
    rst_n = 1'b1;

    // R1 masking, R2 masking
    write_sw(32'hffff_ffff);
    write_ipl(8'he5);
    write_ipl(8'h00);

    // R3 lowest and highest software bit
    write_sw(32'h0000_0010);
    do_eval(32'h0, 1'b0);
    write_sw(32'h0004_0010);
    do_eval(32'h0, 1'b0);
    // R6 pulse lasts one cycle
    @(negedge clk);
    chk("R6 pulse width", 32'(take), 0);

    // R6 equal level not taken, R8 hold
    write_ipl(8'd15);
    do_eval(32'h0, 1'b0);
    write_ipl(8'd14);
    do_eval(32'h0, 1'b0);

    // R4 external overrides software
    write_ipl(8'd0);
    write_sw(32'h0007_fff0);
    do_eval(32'h0010_0000, 1'b0);
    do_eval(32'h0090_0000, 1'b0);

    // R5 out-of-range external ignored
    write_sw(32'h0);
    do_eval(32'hff0f_ffff, 1'b0);
    write_sw(32'h0000_0100);
    do_eval(32'h0f08_000f, 1'b0);

    // R9 async request flagged, level unaffected
    write_sw(32'h0000_0800);
    do_eval(32'h0, 1'b1);
    write_ipl(8'd31);
    do_eval(32'h0080_0000, 1'b1);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int unsigned r = $urandom;
      if (r[0]) write_sw($urandom);
      if (r[2:1] == 2'b00) write_ipl(8'($urandom_range(0, 255)));
      if (r[4:3] == 2'b00) write_ipl(8'($urandom_range(0, 20)));
      do_eval(r[6] ? $urandom : ($urandom & 32'hff0f_ffff), r[8:7] == 2'b00);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule